// File: doc/BRIEF.md
# Preset-Sequencing High-Speed Event Counter

This block counts encoder pulses in hardware so that a slow host never has to take part in each count. It holds a 32-bit up/down count. An index walks through a small programmable table of compare values, and each table entry has its own 8-bit pattern for the discrete outputs. The outputs show the pattern of the active entry.

When a count step lands on the active compare value, the block flags a match and moves to the next entry. It stops at the last active entry. A once-per-revolution reset pulse zeroes the count and sends the index back to entry 0. A reversal of the direction input is flagged as a separate event.

The three event flags are sticky and each has its own enable bit. A single interrupt line combines the enabled flags, and the host clears flags by writing ones to a clear register. All three pulse inputs pass through two-flop synchronizers and are edge-detected in the system clock domain.

Top module: `preset_seq_counter`

## Requirements
- R1: While reset is held and right after it, the count is 0, the entry index is 0, all status flags are 0, the interrupt line is low, and the outputs show the entry-0 pattern. All table contents reset to 0.
- R2: Each rising edge of `cntIn` changes the count by one. It counts up when `dirIn` is 1 and down when it is 0, modulo 2^32. The step appears on `countVal` three clock edges after the input edge.
- R3: When a count step makes the count equal to the active entry's compare value, status bit 0 (match) is set. The index then advances by one, and `outPins` switch to the next entry's pattern.
- R4: The index never goes past the last active entry, which is the active-count register minus one. An active count of 0 is treated as 1. A match on the last entry sets the flag and leaves the index where it is.
- R5: A rising edge of `revIn` sets the count to 0 and the index to 0, and sets status bit 1 (revolution).
- R6: When a count edge and a revolution edge are detected in the same cycle, the revolution edge wins. The count becomes 0, not ±1.
- R7: Each change of the synchronized `dirIn` level sets status bit 2 (direction), once per reversal.
- R8: Status bits stay set until cleared. Writing a 1 to a bit of the clear register clears that bit. A new event in the same cycle keeps the bit set. `irqLine` is high exactly when some status bit and its enable bit are both 1.
- R9: Register map by `wrAddr`. Bits [4:3]=0 writes compare value [2:0]. Bits [4:3]=1 writes pattern [2:0] from `wrData[7:0]`. Address 0x10 writes the active count, 0x11 writes the enable mask `wrData[2:0]`, and 0x12 is the write-one-to-clear register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntIn | input | 1 | Count pulse from the encoder |
| dirIn | input | 1 | Count direction, 1 = up |
| revIn | input | 1 | Once-per-revolution reset pulse |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register address |
| wrData | input | 32 | Register write data |
| outPins | output | 8 | Pattern of the active table entry |
| countVal | output | 32 | Current count |
| entryIdx | output | 3 | Active table entry |
| irqStatus | output | 3 | Sticky flags: bit0 match, bit1 revolution, bit2 direction |
| irqLine | output | 1 | OR of enabled pending flags |

## Verification
The hardest case to reach is a count edge and a revolution edge detected in the same system clock cycle. Random encoder traffic almost never lines them up through the synchronizers. The bench raises `cntIn` and `revIn` on the same clock edge after the count has been moved away from zero, so both edges pass the synchronizers together. A plain reset would leave 0 and a reset that lost to the count would leave ±1, so the bench can tell the two apart. A second case is holding the index at the last entry, which the bench reaches by matching the last compare value and then matching it again from the other direction.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef struct packed {
    logic cntEv;
    logic revEv;
    logic dirChg;
    logic dirUp;
    logic wrPreset;
    logic wrPattern;
    logic wrActive;
  } psc_strobe_t;

  localparam int STAT_W = 3;
endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
  import psc_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntSync,
  input  logic              dirSync,
  input  logic              revSync,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic              matchHit,
  output psc_strobe_t       strb,
  output logic [STAT_W-1:0] irqStatus,
  output logic              irqLine
);
  localparam logic [1:0] SEL_PRESET  = 2'd0;
  localparam logic [1:0] SEL_PATTERN = 2'd1;
  localparam logic [1:0] SEL_CTRL    = 2'd2;
  localparam int         LOW_W       = AW - 2;
  localparam logic [LOW_W-1:0] REG_ACTIVE = LOW_W'(0);
  localparam logic [LOW_W-1:0] REG_ENABLE = LOW_W'(1);
  localparam logic [LOW_W-1:0] REG_CLEAR  = LOW_W'(2);

  logic cntPrev, dirPrev, revPrev;
  logic [STAT_W-1:0] irqEnable;
  logic [STAT_W-1:0] setMask, clrMask;
  logic [1:0]        sel;
  logic [LOW_W-1:0]  low;
  logic              ctrlWr;

  assign sel    = wrAddr[AW-1:AW-2];
  assign low    = wrAddr[LOW_W-1:0];
  assign ctrlWr = wrEn && (sel == SEL_CTRL);

  always_comb begin
    strb.cntEv     = cntSync & ~cntPrev;
    strb.revEv     = revSync & ~revPrev;
    strb.dirChg    = dirSync ^ dirPrev;
    strb.dirUp     = dirSync;
    strb.wrPreset  = wrEn && (sel == SEL_PRESET);
    strb.wrPattern = wrEn && (sel == SEL_PATTERN);
    strb.wrActive  = ctrlWr && (low == REG_ACTIVE);
  end

  assign setMask = {strb.dirChg, strb.revEv, matchHit};
  assign clrMask = (ctrlWr && (low == REG_CLEAR)) ? wrData[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntPrev   <= 1'b0;
      dirPrev   <= 1'b0;
      revPrev   <= 1'b0;
      irqStatus <= '0;
      irqEnable <= '0;
    end else begin
      cntPrev   <= cntSync;
      dirPrev   <= dirSync;
      revPrev   <= revSync;
      irqStatus <= (irqStatus & ~clrMask) | setMask;
      if (ctrlWr && (low == REG_ENABLE))
        irqEnable <= wrData[STAT_W-1:0];
    end
  end

  assign irqLine = |(irqStatus & irqEnable);
endmodule

// File: rtl/psc_datapath.sv
module psc_datapath
  import psc_pkg::*;
#(
  parameter int NENT = 8,
  parameter int CW   = 32,
  parameter int PW   = 8,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  psc_strobe_t             strb,
  input  logic [AW-1:0]           wrAddr,
  input  logic [DW-1:0]           wrData,
  output logic                    matchHit,
  output logic [CW-1:0]           countVal,
  output logic [$clog2(NENT)-1:0] entryIdx,
  output logic [PW-1:0]           outPins
);
  localparam int IDXW = $clog2(NENT);
  localparam int ACTW = $clog2(NENT + 1);

  logic [CW-1:0]   presetTab [NENT];
  logic [PW-1:0]   patternTab[NENT];
  logic [ACTW-1:0] activeCnt;
  logic [IDXW-1:0] lastIdx, wrIdx;
  logic [CW-1:0]   nextCount;

  assign wrIdx = wrAddr[IDXW-1:0];

  for (genvar e = 0; e < NENT; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        presetTab[e]  <= '0;
        patternTab[e] <= '0;
      end else begin
        if (strb.wrPreset && wrIdx == IDXW'(e))  presetTab[e]  <= wrData[CW-1:0];
        if (strb.wrPattern && wrIdx == IDXW'(e)) patternTab[e] <= wrData[PW-1:0];
      end
    end
  end

  always_comb begin
    if (activeCnt == '0)                   lastIdx = '0;
    else if (activeCnt >= ACTW'(NENT))     lastIdx = IDXW'(NENT - 1);
    else                                   lastIdx = IDXW'(activeCnt - 1'b1);
  end

  assign nextCount = strb.dirUp ? countVal + 1'b1 : countVal - 1'b1;
  assign matchHit  = strb.cntEv && !strb.revEv && (nextCount == presetTab[entryIdx]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal  <= '0;
      entryIdx  <= '0;
      activeCnt <= ACTW'(NENT);
    end else begin
      if (strb.wrActive) activeCnt <= wrData[ACTW-1:0];
      if (strb.revEv) begin
        countVal <= '0;
        entryIdx <= '0;
      end else if (strb.cntEv) begin
        countVal <= nextCount;
        if (matchHit && entryIdx < lastIdx) entryIdx <= entryIdx + 1'b1;
      end
    end
  end

  assign outPins = patternTab[entryIdx];
endmodule

// File: rtl/preset_seq_counter.sv
module preset_seq_counter
  import psc_pkg::*;
#(
  parameter int NENT = 8,
  parameter int CW   = 32,
  parameter int PW   = 8,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cntIn,
  input  logic                    dirIn,
  input  logic                    revIn,
  input  logic                    wrEn,
  input  logic [AW-1:0]           wrAddr,
  input  logic [DW-1:0]           wrData,
  output logic [PW-1:0]           outPins,
  output logic [CW-1:0]           countVal,
  output logic [$clog2(NENT)-1:0] entryIdx,
  output logic [STAT_W-1:0]       irqStatus,
  output logic                    irqLine
);
  logic [2:0]  syncBus;
  logic        matchHit;
  psc_strobe_t strb;

  psc_sync #(.WIDTH(3)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({revIn, dirIn, cntIn}),
    .syncOut(syncBus)
  );

  psc_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cntSync(syncBus[0]), .dirSync(syncBus[1]), .revSync(syncBus[2]),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .matchHit(matchHit), .strb(strb),
    .irqStatus(irqStatus), .irqLine(irqLine)
  );

  psc_datapath #(.NENT(NENT), .CW(CW), .PW(PW), .AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .wrData(wrData),
    .matchHit(matchHit), .countVal(countVal),
    .entryIdx(entryIdx), .outPins(outPins)
  );
endmodule

// File: rtl/psc_checker.sv
module psc_checker
  import psc_pkg::*;
#(
  parameter int CW   = 32,
  parameter int IDXW = 3,
  parameter int AW   = 5
) (
  input logic              clk,
  input logic              rstN,
  input psc_strobe_t       strb,
  input logic              wrEn,
  input logic [AW-1:0]     wrAddr,
  input logic [31:0]       wrData,
  input logic [CW-1:0]     countVal,
  input logic [IDXW-1:0]   entryIdx,
  input logic [STAT_W-1:0] irqStatus
);
  logic clrRev;
  assign clrRev = wrEn && (wrAddr == AW'(5'h12)) && wrData[1];

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntEv && !strb.revEv && strb.dirUp |=> countVal == $past(countVal) + 1'b1);

  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntEv && !strb.revEv && !strb.dirUp |=> countVal == $past(countVal) - 1'b1);

  assert_index_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.revEv |=> entryIdx >= $past(entryIdx));

  assert_rev_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.revEv |=> countVal == '0 && entryIdx == '0 && irqStatus[1]);

  assert_rev_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.revEv && strb.cntEv |=> countVal == '0);

  assert_dir_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.dirChg |=> irqStatus[2]);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqStatus[1] && !clrRev |=> irqStatus[1]);
endmodule

bind preset_seq_counter psc_checker #(.CW(CW), .IDXW($clog2(NENT)), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .countVal(countVal), .entryIdx(entryIdx), .irqStatus(irqStatus)
);

// File: tb/preset_seq_counter_bench.sv
module preset_seq_counter_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntIn = 1'b0, dirIn = 1'b1, revIn = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  outPins;
  logic [31:0] countVal;
  logic [2:0]  entryIdx;
  logic [2:0]  irqStatus;
  logic        irqLine;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  preset_seq_counter u_preset_seq_counter (
    .clk(clk), .rstN(rstN), .cntIn(cntIn), .dirIn(dirIn), .revIn(revIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outPins(outPins), .countVal(countVal), .entryIdx(entryIdx),
    .irqStatus(irqStatus), .irqLine(irqLine)
  );

  // {dir, rev, pulses[8], expCount[32], expOut[8], expStatus[3]}
  localparam int NV = 11;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd2, 32'd2,          8'h11, 3'b000},
    {1'b1, 1'b0, 8'd1, 32'd3,          8'h22, 3'b001},
    {1'b1, 1'b0, 8'd2, 32'd5,          8'h33, 3'b001},
    {1'b1, 1'b0, 8'd2, 32'd7,          8'h33, 3'b001},
    {1'b1, 1'b0, 8'd3, 32'd10,         8'h33, 3'b000},
    {1'b0, 1'b0, 8'd0, 32'd10,         8'h33, 3'b100},
    {1'b0, 1'b0, 8'd3, 32'd7,          8'h33, 3'b001},
    {1'b0, 1'b1, 8'd0, 32'd0,          8'h11, 3'b010},
    {1'b0, 1'b0, 8'd1, 32'hFFFF_FFFF,  8'h11, 3'b000},
    {1'b1, 1'b0, 8'd1, 32'd0,          8'h11, 3'b100},
    {1'b1, 1'b0, 8'd3, 32'd3,          8'h22, 3'b001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseCnt(input int n);
    for (int i = 0; i < n; i++) begin
      cntIn = 1'b1; idle(4);
      cntIn = 1'b0; idle(4);
    end
  endtask

  task automatic pulseRev();
    revIn = 1'b1; idle(4);
    revIn = 1'b0; idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    check("R1 count", countVal, 0);
    check("R1 index", {29'd0, entryIdx}, 0);
    check("R1 status", {29'd0, irqStatus}, 0);
    check("R1 irq", {31'd0, irqLine}, 0);
    check("R1 outputs", {24'd0, outPins}, 0);
    @(negedge clk); rstN = 1'b1;

    // R9: configure table, active count, enables
    wrReg(5'h00, 32'd3); wrReg(5'h01, 32'd5); wrReg(5'h02, 32'd7);
    wrReg(5'h08, 32'h11); wrReg(5'h09, 32'h22); wrReg(5'h0A, 32'h33);
    wrReg(5'h10, 32'd3);
    wrReg(5'h11, 32'h7);
    idle(6);
    wrReg(5'h12, 32'h7);
    idle(2);
    check("R9 pattern0 visible", {24'd0, outPins}, 32'h11);
    check("R8 cleared", {29'd0, irqStatus}, 0);

    for (int v = 0; v < NV; v++) begin
      dirIn = VEC[v][52];
      idle(6);
      if (VEC[v][51]) pulseRev();
      pulseCnt(int'(VEC[v][50:43]));
      idle(2);
      check("R2 count", countVal, VEC[v][42:11]);
      check("R3 outputs", {24'd0, outPins}, {24'd0, VEC[v][10:3]});
      check("R7 status", {29'd0, irqStatus}, {29'd0, VEC[v][2:0]});
      check("R8 irq line", {31'd0, irqLine}, {31'd0, (VEC[v][2:0] != 3'b000)});
      wrReg(5'h12, 32'h7);
    end

    // R6: simultaneous count and revolution edges, count is 3 here
    cntIn = 1'b1; revIn = 1'b1; idle(4);
    cntIn = 1'b0; revIn = 1'b0; idle(6);
    check("R6 count", countVal, 0);
    check("R6 outputs", {24'd0, outPins}, 32'h11);
    check("R6 status", {29'd0, irqStatus}, 32'h2);
    wrReg(5'h12, 32'h7);

    // R4: one active entry, index stays on entry 0
    wrReg(5'h10, 32'd1);
    pulseCnt(3);
    idle(2);
    check("R4 match flag", {29'd0, irqStatus}, 32'h1);
    check("R4 index held", {29'd0, entryIdx}, 0);
    check("R4 outputs held", {24'd0, outPins}, 32'h11);
    wrReg(5'h12, 32'h7);
    // R4: active count 0 behaves as 1
    wrReg(5'h10, 32'd0);
    pulseRev();
    pulseCnt(3);
    idle(2);
    check("R4 zero active index", {29'd0, entryIdx}, 0);
    wrReg(5'h12, 32'h7);

    // R8: enable masking and partial write-one-to-clear
    wrReg(5'h11, 32'h0);
    pulseRev();
    idle(2);
    check("R8 masked status", {29'd0, irqStatus}, 32'h2);
    check("R8 masked irq", {31'd0, irqLine}, 0);
    wrReg(5'h11, 32'h2);
    idle(1);
    check("R8 enabled irq", {31'd0, irqLine}, 1);
    wrReg(5'h12, 32'h1);
    idle(1);
    check("R8 other bit kept", {29'd0, irqStatus}, 32'h2);
    wrReg(5'h12, 32'h2);
    idle(1);
    check("R8 cleared bit", {29'd0, irqStatus}, 0);
    check("R8 irq low", {31'd0, irqLine}, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule